// File: doc/BRIEF.md
# Circular Debug Trace Buffer

The block records one of four 128-bit debug buses into a circular array of rows for as long as capture is running. Each clock while running, the selected bus is written into the row at the write pointer and the pointer steps forward, wrapping at the array depth. When the array has wrapped, the newest rows overwrite the oldest ones.

Software drives the block through a small register port with 64-bit words. A pulse-style command register starts, stops or clears capture. A configuration register holds the bus select, a hold-off bit and a read-only run flag. Two data registers return the upper and lower halves of a row. Readout happens only through these reads: each read of a data register while capture is stopped returns the row at that half's read pointer and then moves the pointer forward by one, with wrap. Stopping capture points both read pointers at the oldest row, so a full dump comes out oldest first.

A three-state machine governs capture. Its states are IDLE (stopped after power-up or a clear command), RUN (capturing) and HALT (stopped after a capture). The transitions are: IDLE to RUN on start without hold-off; HALT to RUN on start without hold-off; RUN to HALT on stop; and any state to IDLE on a clear command. A stop seen in IDLE leaves the state unchanged.

Top module: `trace_array`

## Requirements
- R1: A read request (`reg_req_i`=1, `reg_we_i`=0) is answered one clock later with `reg_rvalid_o`=1 and the data on `reg_rdata_o`. Writes and idle cycles produce no response.
- R2: After `rst_ni` is released, capture is stopped, the configuration word reads as 0 and all pointers are 0.
- R3: While running, on every clock the bus selected by configuration bits [49:48] (bus k sits at `dbg_bus_i[128k+127:128k]`) is stored in the row at the write pointer, and the write pointer then advances, wrapping from DEPTH-1 to 0.
- R4: While running, a read of the low-data register (address 3) returns 64'h8000_0000_0000_0000 and leaves its pointer unchanged. A read of the high-data register (address 2) returns 0 and leaves its pointer unchanged.
- R5: While stopped, a low-data read returns {1'b0, row[62:0]} of the row at the low pointer, then advances that pointer, wrapping from DEPTH-1 to 0. DEPTH+1 successive reads therefore return the first row twice.
- R6: While stopped, a high-data read returns row[127:64] at the high pointer and advances that pointer under the same rules. The high pointer is independent of the low pointer.
- R7: When capture stops, both read pointers move to the oldest row. That row is the write pointer if the array has wrapped, and row 0 otherwise.
- R8: The command register (address 0) acts on written bit 63 (start), bit 62 (stop) and bit 61 (clear). Clear beats stop, and stop beats start. A read of address 0 returns 0.
- R9: Configuration bit 45 is hold-off. While it is set, a start is ignored. Setting it does not stop a capture already running.
- R10: Configuration bit 44 reads as 1 exactly while capture runs. Writes to this bit have no effect.
- R11: A clear command stops capture and zeroes the write pointer, both read pointers and the wrapped flag. Row contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 2 | 0 command, 1 configuration, 2 high data, 3 low data |
| reg_wdata_i | input | 64 | Write data |
| reg_rvalid_o | output | 1 | Read response valid, one cycle after the request |
| reg_rdata_o | output | 64 | Read response data |
| dbg_bus_i | input | 512 | Four 128-bit debug buses, packed |

## Verification
A read pointer that fails to advance or to wrap shows up on the very next data read, as a repeated or skipped row. An oldest-row pointer set wrong at stop shows up on the first read of the dump, as a row out of order. A wrong run state shows up on the next configuration read through bit 44. It also shows up on the next low read, which returns either the running word or real data. Each of these faults therefore appears at the ports within one read response.

// File: rtl/trace_arr_pkg.sv
package trace_arr_pkg;
    localparam int REG_W = 64;
    localparam int ROW_W = 128;
    localparam int SEL_W = 2;
    localparam int NUM_BUS = 1 << SEL_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } run_state_e;

    typedef enum logic [1:0] {
        RA_CMD = 2'd0,
        RA_CFG = 2'd1,
        RA_HI  = 2'd2,
        RA_LO  = 2'd3
    } reg_addr_e;

    // bit numbering counted from the most significant end
    function automatic int msb0(input int n);
        return REG_W - 1 - n;
    endfunction

    localparam int CMD_START = msb0(0);
    localparam int CMD_STOP  = msb0(1);
    localparam int CMD_CLEAR = msb0(2);
    localparam int CFG_SEL_H = msb0(14);
    localparam int CFG_SEL_L = msb0(15);
    localparam int CFG_HOLD  = msb0(18);
    localparam int CFG_RUN   = msb0(19);
    localparam int LO_BUSY   = msb0(0);
endpackage

// File: rtl/trace_arr_fsm.sv
module trace_arr_fsm
    import trace_arr_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cmd_start_i,
    input  logic cmd_stop_i,
    input  logic cmd_clear_i,
    input  logic hold_i,
    output logic running_o,
    output logic stop_evt_o,
    output logic clear_evt_o
);
    run_state_e state_q, state_d;
    logic       go;

    assign go = cmd_start_i && !hold_i && !cmd_stop_i && !cmd_clear_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go) state_d = ST_RUN;
            ST_RUN: begin
                if (cmd_clear_i)     state_d = ST_IDLE;
                else if (cmd_stop_i) state_d = ST_HALT;
            end
            ST_HALT: begin
                if (cmd_clear_i) state_d = ST_IDLE;
                else if (go)     state_d = ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        running_o   = (state_q == ST_RUN);
        stop_evt_o  = (state_q == ST_RUN) && cmd_stop_i && !cmd_clear_i;
        clear_evt_o = cmd_clear_i;
    end
endmodule

// File: rtl/trace_arr_ptrs.sv
module trace_arr_ptrs #(
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  cap_i,
    input  logic                  stop_evt_i,
    input  logic                  clear_i,
    input  logic [1:0]            adv_i,
    output logic [PTR_W-1:0]      wptr_o,
    output logic [1:0][PTR_W-1:0] rptr_o
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] wptr_q, wptr_nx, oldest;
    logic             wrap_q, wrap_nx;

    always_comb begin
        wptr_nx = wptr_q;
        wrap_nx = wrap_q;
        if (cap_i) begin
            if (wptr_q == LAST) begin
                wptr_nx = '0;
                wrap_nx = 1'b1;
            end else begin
                wptr_nx = wptr_q + 1'b1;
            end
        end
        oldest = wrap_nx ? wptr_nx : '0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni || clear_i) begin
            wptr_q <= '0;
            wrap_q <= 1'b0;
        end else begin
            wptr_q <= wptr_nx;
            wrap_q <= wrap_nx;
        end
    end

    assign wptr_o = wptr_q;

    // index 0: high half, index 1: low half
    for (genvar g = 0; g < 2; g++) begin : g_rd
        logic [PTR_W-1:0] rp_q;
        always_ff @(posedge clk_i) begin
            if (!rst_ni || clear_i)  rp_q <= '0;
            else if (stop_evt_i)     rp_q <= oldest;
            else if (adv_i[g])       rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
        end
        assign rptr_o[g] = rp_q;
    end
endmodule

// File: rtl/trace_arr_store.sv
module trace_arr_store
    import trace_arr_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PTR_W = 4
) (
    input  logic                     clk_i,
    input  logic                     we_i,
    input  logic [SEL_W-1:0]         sel_i,
    input  logic [NUM_BUS*ROW_W-1:0] bus_i,
    input  logic [PTR_W-1:0]         wptr_i,
    input  logic [PTR_W-1:0]         rptr_hi_i,
    input  logic [PTR_W-1:0]         rptr_lo_i,
    output logic [REG_W-1:0]         hi_o,
    output logic [REG_W-1:0]         lo_o
);
    logic [ROW_W-1:0] lane [NUM_BUS];
    logic [ROW_W-1:0] rows [DEPTH];
    logic [ROW_W-1:0] row_hi, row_lo;

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_lane
        assign lane[b] = bus_i[b*ROW_W +: ROW_W];
    end

    always_ff @(posedge clk_i) begin
        if (we_i) rows[wptr_i] <= lane[sel_i];
    end

    assign row_hi = rows[rptr_hi_i];
    assign row_lo = rows[rptr_lo_i];
    assign hi_o   = row_hi[ROW_W-1:REG_W];
    assign lo_o   = row_lo[REG_W-1:0];

    logic unused_halves;
    assign unused_halves = ^{row_hi[REG_W-1:0], row_lo[ROW_W-1:REG_W]};
endmodule

// File: rtl/trace_array.sv
module trace_array
    import trace_arr_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         reg_req_i,
    input  logic         reg_we_i,
    input  logic [1:0]   reg_addr_i,
    input  logic [63:0]  reg_wdata_i,
    output logic         reg_rvalid_o,
    output logic [63:0]  reg_rdata_o,
    input  logic [511:0] dbg_bus_i
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    reg_addr_e        addr;
    logic             is_rd, is_wr, cmd_wr;
    logic             running, stop_evt, clear_evt;
    logic [SEL_W-1:0] sel_q;
    logic             hold_q;
    logic [1:0]       adv;
    logic [PTR_W-1:0] wptr;
    logic [1:0][PTR_W-1:0] rptr;
    logic [PTR_W-1:0] rp_lo;
    logic [REG_W-1:0] hi_word, lo_word, rdata_d, rdata_q;
    logic             rvalid_q;

    assign addr   = reg_addr_e'(reg_addr_i);
    assign is_rd  = reg_req_i && !reg_we_i;
    assign is_wr  = reg_req_i && reg_we_i;
    assign cmd_wr = is_wr && (addr == RA_CMD);
    assign rp_lo  = rptr[1];

    trace_arr_fsm u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cmd_start_i (cmd_wr && reg_wdata_i[CMD_START]),
        .cmd_stop_i  (cmd_wr && reg_wdata_i[CMD_STOP]),
        .cmd_clear_i (cmd_wr && reg_wdata_i[CMD_CLEAR]),
        .hold_i      (hold_q),
        .running_o   (running),
        .stop_evt_o  (stop_evt),
        .clear_evt_o (clear_evt)
    );

    always_comb begin
        adv[0] = is_rd && (addr == RA_HI) && !running;
        adv[1] = is_rd && (addr == RA_LO) && !running;
    end

    trace_arr_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cap_i      (running),
        .stop_evt_i (stop_evt),
        .clear_i    (clear_evt),
        .adv_i      (adv),
        .wptr_o     (wptr),
        .rptr_o     (rptr)
    );

    trace_arr_store #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
        .clk_i     (clk_i),
        .we_i      (running),
        .sel_i     (sel_q),
        .bus_i     (dbg_bus_i),
        .wptr_i    (wptr),
        .rptr_hi_i (rptr[0]),
        .rptr_lo_i (rptr[1]),
        .hi_o      (hi_word),
        .lo_o      (lo_word)
    );

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sel_q  <= '0;
            hold_q <= 1'b0;
        end else if (is_wr && addr == RA_CFG) begin
            sel_q  <= reg_wdata_i[CFG_SEL_H:CFG_SEL_L];
            hold_q <= reg_wdata_i[CFG_HOLD];
        end
    end

    always_comb begin
        rdata_d = '0;
        unique case (addr)
            RA_CMD: rdata_d = '0;
            RA_CFG: begin
                rdata_d[CFG_SEL_H:CFG_SEL_L] = sel_q;
                rdata_d[CFG_HOLD]            = hold_q;
                rdata_d[CFG_RUN]             = running;
            end
            RA_HI:  rdata_d = running ? '0 : hi_word;
            RA_LO: begin
                if (running) rdata_d[LO_BUSY] = 1'b1;
                else         rdata_d = {1'b0, lo_word[REG_W-2:0]};
            end
            default: rdata_d = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= is_rd;
            if (is_rd) rdata_q <= rdata_d;
        end
    end

    assign reg_rvalid_o = rvalid_q;
    assign reg_rdata_o  = rdata_q;

    logic unused_wdata;
    assign unused_wdata = ^{reg_wdata_i, lo_word[REG_W-1]};
endmodule

// File: rtl/trace_array_chk.sv
module trace_array_chk #(
    parameter int DEPTH = 16,
    parameter int PTR_W = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             reg_req_i,
    input logic             reg_we_i,
    input logic [1:0]       reg_addr_i,
    input logic             reg_rvalid_o,
    input logic [63:0]      reg_rdata_o,
    input logic             running,
    input logic             hold_q,
    input logic [PTR_W-1:0] rp_lo
);
    logic rd_lo, rd_any;
    assign rd_any = reg_req_i && !reg_we_i;
    assign rd_lo  = rd_any && reg_addr_i == 2'd3;

    // R1
    a_r1_read_answered: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_any |=> reg_rvalid_o);
    a_r1_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_any |=> !reg_rvalid_o);
    // R4
    a_r4_busy_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_lo && running) |=> reg_rdata_o == 64'h8000_0000_0000_0000);
    a_r4_lo_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_lo && running) |=> $stable(rp_lo));
    // R5
    a_r5_lo_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_lo && !running && rp_lo == PTR_W'(DEPTH - 1)) |=> rp_lo == '0);
    // R9
    a_r9_hold_blocks_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!running && hold_q && reg_req_i && reg_we_i && reg_addr_i == 2'd0) |=> !running);
    // R10
    a_r10_run_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_any && reg_addr_i == 2'd1) |=> reg_rdata_o[44] == $past(running));
endmodule

bind trace_array trace_array_chk #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .reg_req_i    (reg_req_i),
    .reg_we_i     (reg_we_i),
    .reg_addr_i   (reg_addr_i),
    .reg_rvalid_o (reg_rvalid_o),
    .reg_rdata_o  (reg_rdata_o),
    .running      (running),
    .hold_q       (hold_q),
    .rp_lo        (rp_lo)
);

// File: tb/trace_array_test.sv
`timescale 1ns/1ps
module trace_array_test;
    localparam int DEPTH = 16;
    localparam logic [63:0] START = 64'h8000_0000_0000_0000;
    localparam logic [63:0] STOP  = 64'h4000_0000_0000_0000;
    localparam logic [63:0] CLEAR = 64'h2000_0000_0000_0000;
    localparam logic [63:0] SEL2  = 64'h0002_0000_0000_0000;
    localparam logic [63:0] HOLD  = 64'h0000_2000_0000_0000;
    localparam logic [63:0] RUNB  = 64'h0000_1000_0000_0000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req = 1'b0, we = 1'b0;
    logic [1:0]   addr = '0;
    logic [63:0]  wdata = '0;
    logic         rvalid;
    logic [63:0]  rdata;
    logic [511:0] bus = '0;

    int n_vec = 0, n_bad = 0;
    bit done = 0;
    logic [63:0] exp_q[$];
    string       tag_q[$];

    trace_array #(.DEPTH(DEPTH)) uut (
        .clk_i(clk), .rst_ni(rst_n), .reg_req_i(req), .reg_we_i(we),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rvalid_o(rvalid),
        .reg_rdata_o(rdata), .dbg_bus_i(bus)
    );

    always #10 clk = ~clk;

    function automatic logic [127:0] pat(input int b, input int i);
        return {8'hB0 + 8'(b), 24'h00C0DE, 32'(i) + 32'h100,
                16'hF00D, 8'(b), 8'h00, 32'(i * 7 + 1)};
    endfunction
    function automatic logic [63:0] lo_of(input logic [127:0] p);
        return {1'b0, p[62:0]};
    endfunction
    function automatic logic [63:0] hi_of(input logic [127:0] p);
        return p[127:64];
    endfunction

    task automatic note(input bit ok, input string t, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", t, act, exp);
        end
    endtask

    // monitor: pops expectations as responses appear
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            if (exp_q.size() == 0) note(0, "R1 unexpected response", rdata, '0);
            else begin
                automatic logic [63:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                note(rdata === e, t, rdata, e);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [63:0] d);
        @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
        @(posedge clk); #1 req = 0; we = 0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [63:0] e, input string t);
        @(negedge clk); req = 1; we = 0; addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(posedge clk); #1 req = 0;
    endtask

    // start, capture n rows (stop lands on the edge of the last one)
    task automatic cap(input int n);
        wr(2'd0, START);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            for (int b = 0; b < 4; b++) bus[b*128 +: 128] = pat(b, i);
            if (i == n - 1) begin req = 1; we = 1; addr = 2'd0; wdata = STOP; end
            @(posedge clk);
        end
        #1 req = 0; we = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        note(rvalid === 1'b0, "R2 rvalid after reset", 64'(rvalid), 0);
        rd(2'd1, 64'h0, "R2 config at reset");
        rd(2'd0, 64'h0, "R8 command reads zero");

        // partial dump, bus 0
        cap(5);
        rd(2'd1, 64'h0, "R10 stopped flag");
        for (int k = 0; k < 5; k++) rd(2'd3, lo_of(pat(0, k)), "R3 R5 partial low");
        rd(2'd2, hi_of(pat(0, 0)), "R6 high pointer independent");
        rd(2'd2, hi_of(pat(0, 1)), "R6 high advance");

        // bus 2, write to run flag ignored
        wr(2'd1, SEL2 | RUNB);
        rd(2'd1, SEL2, "R10 run bit not writable");

        // wrapped dump
        cap(DEPTH + 5);
        for (int k = 0; k < DEPTH; k++) rd(2'd3, lo_of(pat(2, 5 + k)), "R7 R3 oldest first");
        rd(2'd3, lo_of(pat(2, 5)), "R5 low wrap");
        rd(2'd2, hi_of(pat(2, 5)), "R7 high oldest");
        rd(2'd2, hi_of(pat(2, 6)), "R6 high next");

        // hold-off
        wr(2'd1, SEL2 | HOLD);
        wr(2'd0, START);
        rd(2'd1, SEL2 | HOLD, "R9 start blocked");
        wr(2'd1, SEL2);
        wr(2'd0, START);
        rd(2'd1, SEL2 | RUNB, "R10 running flag");
        wr(2'd1, SEL2 | HOLD);
        rd(2'd1, SEL2 | HOLD | RUNB, "R9 hold does not stop");
        rd(2'd3, 64'h8000_0000_0000_0000, "R4 low while running");
        rd(2'd2, 64'h0, "R4 high while running");
        wr(2'd0, START | STOP);
        rd(2'd1, SEL2 | HOLD, "R8 stop beats start");

        // clear
        wr(2'd1, 64'h0);
        wr(2'd0, CLEAR);
        cap(DEPTH + 5);
        rd(2'd3, lo_of(pat(0, 5)), "R7 oldest after wrap");
        wr(2'd0, CLEAR);
        rd(2'd3, lo_of(pat(0, DEPTH)), "R11 pointers to row 0");
        rd(2'd2, hi_of(pat(0, DEPTH)), "R11 high pointer row 0");
        wr(2'd0, START);
        wr(2'd0, CLEAR | START);
        rd(2'd1, 64'h0, "R11 clear stops capture");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) note(0, "R1 missing responses", 64'(exp_q.size()), 0);
        finish_run();
    end
endmodule